// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block takes a stream of 32-bit command words and cuts it into whole command packets for a rendering engine downstream. The top byte of the first word of each packet is its opcode. The opcode sets how many words follow. For most opcodes that count comes from a fixed per-opcode table. For the two polyline families, the packet instead runs until a terminator word is found. Words are gathered in a local buffer until the packet is complete. The packet is then replayed on the output, one word per cycle, with start and end markers, the opcode and the total word count.

Image-transfer opcodes do not produce a packet. Once their three words have arrived, the block raises a one-cycle strobe that hands the position word and the size word to a separate transfer engine, together with the transfer direction. Environment opcodes write the whole command word into a shadow register file of eight entries, and are also passed downstream as one-word packets. After every completed command, a 13-bit status field is refreshed from two of those shadow entries.

The control is a three-state machine:
- **GATHER** accepts input words.
- **EMIT** replays a finished packet.
- **XFER** issues the transfer strobe.

Transitions:
- GATHER→EMIT when the last word of a drawing or environment packet is accepted.
- GATHER→XFER when the third word of an image-transfer command is accepted.
- EMIT→GATHER after the last word has been replayed.
- XFER→GATHER after one cycle.

Top module: `gfx_pkt_framer`

## Requirements
- R1: After reset:
  - `in_ready` is 1, and `pkt_valid` and `xfer_valid` are 0.
  - `stat_bits` is 0.
  - Shadow entry i reads as (0xE0+i)<<24.
- R2: The opcode is bits 31:24 of the first word. A table-driven packet has 1+E words, where E is:
  - 2 for 0x02, 0x40–0x47 and 0x60–0x63.
  - For the eight groups of four starting at 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34, 0x38 and 0x3C: 3, 6, 4, 8, 5, 8, 7 and 11.
  - 3 for 0x50–0x57, 0x64–0x67 and 0x80.
  - 1 for 0x68–0x6B, 0x70–0x73 and 0x78–0x7B.
  - 2 for 0x74–0x77 and 0x7C–0x7F.
- R3: Every other non-image, non-polyline opcode (E = 0, for example 0x00, 0x6C, 0xFF) forms a one-word packet.
- R4: For opcodes 0x48–0x4F, the packet ends at the first word with index 3 or more (first word is index 0) whose value ANDed with 0xF000F000 equals 0x50005000. That terminator is included in the packet.
- R5: For opcodes 0x58–0x5F, only words at even indices 4, 6, 8, … are tested against the same terminator pattern. A matching word at an odd index is ordinary packet data.
- R6: A polyline that reaches DEPTH words (default 32) without a terminator is closed at DEPTH words.
- R7: Nothing of a packet appears on the output until its last word has been accepted. Idle gaps between input words are allowed. `in_ready` is 0 while a packet is replayed and while a transfer strobe is raised.
- R8: A packet is replayed on consecutive cycles:
  - `pkt_first` marks the first word and `pkt_last` marks the last word.
  - Words appear in arrival order.
  - `pkt_opcode` and `pkt_count` (the total word count) are constant over the packet.
- R9: Opcodes 0xA0–0xDF take three words and produce no packet. They produce one single-cycle `xfer_valid` with `xfer_pos` = word 1 and `xfer_size` = word 2. `xfer_read` is 1 for 0xC0–0xDF and 0 for 0xA0–0xBF.
- R10: Opcodes 0xE0–0xE7 store the whole word into shadow entry opcode[2:0], readable through `env_sel`/`env_data`, and are also emitted as one-word packets.
- R11: After each completed command, `stat_bits[10:0]` equals shadow entry 1 bits 10:0 and `stat_bits[12:11]` equals shadow entry 6 bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_word | input | 32 | Input command word |
| in_ready | output | 1 | Block accepts a word this cycle |
| pkt_valid | output | 1 | Packet word present |
| pkt_first | output | 1 | First word of packet |
| pkt_last | output | 1 | Last word of packet |
| pkt_word | output | 32 | Packet word |
| pkt_opcode | output | 8 | Opcode of current packet |
| pkt_count | output | 6 | Total words in current packet |
| xfer_valid | output | 1 | Image-transfer hand-off strobe |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| env_sel | input | 3 | Shadow entry select |
| env_data | output | 32 | Selected shadow entry |
| stat_bits | output | 13 | Status field from shadow entries |

## Verification
The assertions assume that the downstream side always takes a packet word in the cycle it appears. They also assume that `in_word` is only meaningful while `in_valid` is high. The bench respects both: it never stalls the output, and it only changes the offered word after a handshake completes or between offers. Stimulus comes from a seeded random generator. Polyline vertices are drawn with a top nibble that can never match the terminator, and each terminator is placed only at a position the requirements allow. This keeps the bench's own length calculation unambiguous. Directed cases add idle gaps, a stray terminator at an odd index, and buffer overflow.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

    typedef enum logic [1:0] {
        ST_GATHER,
        ST_EMIT,
        ST_XFER
    } gpf_state_e;

    typedef enum logic [1:0] {
        KIND_FIXED,
        KIND_POLY_ALL,
        KIND_POLY_ALT,
        KIND_IMAGE
    } gpf_kind_e;

    localparam logic [31:0] TERM_MASK  = 32'hF000_F000;
    localparam logic [31:0] TERM_MATCH = 32'h5000_5000;

    function automatic logic [3:0] table_extra(input logic [7:0] op);
        logic [3:0] e;
        e = 4'd0;
        if (op == 8'h02) begin
            e = 4'd2;
        end else if (op[7:5] == 3'b001) begin
            unique case (op[4:2])
                3'd0: e = 4'd3;
                3'd1: e = 4'd6;
                3'd2: e = 4'd4;
                3'd3: e = 4'd8;
                3'd4: e = 4'd5;
                3'd5: e = 4'd8;
                3'd6: e = 4'd7;
                default: e = 4'd11;
            endcase
        end else if (op[7:3] == 5'b01000) begin
            e = 4'd2;
        end else if (op[7:3] == 5'b01010) begin
            e = 4'd3;
        end else if (op[7:4] == 4'h6) begin
            unique case (op[3:2])
                2'd0: e = 4'd2;
                2'd1: e = 4'd3;
                2'd2: e = 4'd1;
                default: e = 4'd0;
            endcase
        end else if (op[7:4] == 4'h7) begin
            e = op[2] ? 4'd2 : 4'd1;
        end else if (op == 8'h80) begin
            e = 4'd3;
        end
        return e;
    endfunction

    function automatic gpf_kind_e op_kind(input logic [7:0] op);
        if (op[7:3] == 5'b01001)               return KIND_POLY_ALL;
        if (op[7:3] == 5'b01011)               return KIND_POLY_ALT;
        if (op >= 8'hA0 && op <= 8'hDF)        return KIND_IMAGE;
        return KIND_FIXED;
    endfunction

endpackage

// File: rtl/gpf_op_decode.sv
module gpf_op_decode
    import gpf_pkg::*;
(
    input  logic [7:0] op,
    output gpf_kind_e  kind,
    output logic [3:0] extra
);
    always_comb begin
        kind  = op_kind(op);
        extra = table_extra(op);
    end
endmodule

// File: rtl/gpf_pkt_buffer.sv
module gpf_pkt_buffer #(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    output logic [31:0]   word1,
    output logic [31:0]   word2
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
    assign word1   = mem[1];
    assign word2   = mem[2];
endmodule

// File: rtl/gpf_shadow_file.sv
module gpf_shadow_file #(
    parameter  int NREG = 8,
    localparam int SW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic          refresh,
    input  logic [SW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    output logic [12:0]   status
);
    logic [31:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= {8'(32'hE0 + g), 24'h0};
            end else if (wr_en && wr_idx == SW'(g)) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (refresh) begin
            status <= {regs[6][1:0], regs[1][10:0]};
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/gfx_pkt_framer.sv
module gfx_pkt_framer
    import gpf_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   in_word,
    output logic          in_ready,
    output logic          pkt_valid,
    output logic          pkt_first,
    output logic          pkt_last,
    output logic [31:0]   pkt_word,
    output logic [7:0]    pkt_opcode,
    output logic [CW-1:0] pkt_count,
    output logic          xfer_valid,
    output logic          xfer_read,
    output logic [31:0]   xfer_pos,
    output logic [31:0]   xfer_size,
    input  logic [2:0]    env_sel,
    output logic [31:0]   env_data,
    output logic [12:0]   stat_bits
);
    gpf_state_e    state;
    logic [CW-1:0] idx;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rd_q;
    logic [7:0]    op_q;

    logic [7:0]    cur_op;
    gpf_kind_e     kind;
    logic [3:0]    extra;
    logic          accept;
    logic          is_term;
    logic          done;
    logic          at_cap;
    logic          emit_end;
    logic          env_wr;
    logic [31:0]   buf_rd;
    logic [31:0]   buf_w1;
    logic [31:0]   buf_w2;

    assign cur_op   = (idx == '0) ? in_word[31:24] : op_q;
    assign accept   = in_valid && in_ready;
    assign is_term  = (in_word & TERM_MASK) == TERM_MATCH;
    assign at_cap   = idx == CW'(DEPTH - 1);
    assign emit_end = (state == ST_EMIT) && (rd_q == cnt_q - 1'b1);
    assign env_wr   = accept && (idx == '0) && (in_word[31:27] == 5'b11100);

    gpf_op_decode u_dec (
        .op    (cur_op),
        .kind  (kind),
        .extra (extra)
    );

    always_comb begin
        unique case (kind)
            KIND_FIXED:    done = idx == CW'(extra);
            KIND_POLY_ALL: done = (idx >= CW'(3) && is_term) || at_cap;
            KIND_POLY_ALT: done = (idx >= CW'(4) && !idx[0] && is_term) || at_cap;
            KIND_IMAGE:    done = idx == CW'(2);
            default:       done = 1'b1;
        endcase
    end

    gpf_pkt_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (AW'(idx)),
        .wr_data (in_word),
        .rd_idx  (AW'(rd_q)),
        .rd_data (buf_rd),
        .word1   (buf_w1),
        .word2   (buf_w2)
    );

    gpf_shadow_file #(.NREG(8)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (env_wr),
        .wr_idx  (in_word[26:24]),
        .wr_data (in_word),
        .refresh (emit_end || state == ST_XFER),
        .rd_idx  (env_sel),
        .rd_data (env_data),
        .status  (stat_bits)
    );

    // state register and packet bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_GATHER;
            idx   <= '0;
            cnt_q <= '0;
            rd_q  <= '0;
            op_q  <= '0;
        end else begin
            unique case (state)
                ST_GATHER: begin
                    if (accept) begin
                        if (idx == '0) begin
                            op_q <= in_word[31:24];
                        end
                        if (done) begin
                            idx   <= '0;
                            cnt_q <= idx + 1'b1;
                            rd_q  <= '0;
                            state <= (kind == KIND_IMAGE) ? ST_XFER : ST_EMIT;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_EMIT: begin
                    rd_q <= rd_q + 1'b1;
                    if (emit_end) begin
                        state <= ST_GATHER;
                    end
                end
                ST_XFER: begin
                    state <= ST_GATHER;
                end
                default: state <= ST_GATHER;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        pkt_valid  = 1'b0;
        pkt_first  = 1'b0;
        pkt_last   = 1'b0;
        xfer_valid = 1'b0;
        unique case (state)
            ST_GATHER: in_ready = 1'b1;
            ST_EMIT: begin
                pkt_valid = 1'b1;
                pkt_first = rd_q == '0;
                pkt_last  = emit_end;
            end
            ST_XFER:   xfer_valid = 1'b1;
            default:   in_ready = 1'b0;
        endcase
        pkt_word   = buf_rd;
        pkt_opcode = op_q;
        pkt_count  = cnt_q;
        xfer_read  = op_q[7:5] == 3'b110;
        xfer_pos   = buf_w1;
        xfer_size  = buf_w2;
    end
endmodule

// File: rtl/gpf_checker.sv
module gpf_checker #(
    parameter  int DEPTH = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          pkt_valid,
    input logic          pkt_first,
    input logic          pkt_last,
    input logic [7:0]    pkt_opcode,
    input logic [CW-1:0] pkt_count,
    input logic          xfer_valid,
    input logic [12:0]   stat_bits
);
    logic [7:0] beat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (pkt_valid) begin
            beat <= pkt_last ? 8'd0 : beat + 8'd1;
        end
    end

    AST_READY_LOW_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid || xfer_valid) |-> !in_ready); // R7

    AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> !xfer_valid); // R9

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && xfer_valid)); // R9

    AST_BEATS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |=> (pkt_valid && !pkt_first)); // R8

    AST_HEADER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |=> ($stable(pkt_opcode) && $stable(pkt_count))); // R8

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_last) |-> ((beat + 8'd1) == 8'(pkt_count))); // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_count >= CW'(1) && pkt_count <= CW'(DEPTH))); // R6

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |=> $stable(stat_bits)); // R11
endmodule

bind gfx_pkt_framer gpf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .pkt_valid  (pkt_valid),
    .pkt_first  (pkt_first),
    .pkt_last   (pkt_last),
    .pkt_opcode (pkt_opcode),
    .pkt_count  (pkt_count),
    .xfer_valid (xfer_valid),
    .stat_bits  (stat_bits)
);

// File: tb/gfx_pkt_framer_bench.sv
module gfx_pkt_framer_bench;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        pkt_valid, pkt_first, pkt_last;
    logic [31:0] pkt_word;
    logic [7:0]  pkt_opcode;
    logic [5:0]  pkt_count;
    logic        xfer_valid, xfer_read;
    logic [31:0] xfer_pos, xfer_size;
    logic [2:0]  env_sel = '0;
    logic [31:0] env_data;
    logic [12:0] stat_bits;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] cmd_w [64];
    logic [31:0] cap_w [64];
    logic [15:0] cap_h [64];
    int          cap_n = 0;
    int          cap_x = 0;
    logic        cx_read;
    logic [31:0] cx_pos, cx_size;
    logic [31:0] sh [8];

    always #(PERIOD/2) clk = ~clk;

    gfx_pkt_framer u_gfx_pkt_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_first(pkt_first),
        .pkt_last(pkt_last), .pkt_word(pkt_word), .pkt_opcode(pkt_opcode),
        .pkt_count(pkt_count), .xfer_valid(xfer_valid), .xfer_read(xfer_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size), .env_sel(env_sel),
        .env_data(env_data), .stat_bits(stat_bits)
    );

    // output monitor, away from the active edge
    initial forever begin
        @(negedge clk);
        if (rst_n && pkt_valid && cap_n < 64) begin
            cap_w[cap_n] = pkt_word;
            cap_h[cap_n] = {pkt_first, pkt_last, pkt_opcode, pkt_count};
            cap_n++;
        end
        if (rst_n && xfer_valid) begin
            cap_x++;
            cx_read = xfer_read;
            cx_pos  = xfer_pos;
            cx_size = xfer_size;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int exp_extra(input logic [7:0] op);
        if (op == 8'h02) return 2;
        if (op inside {[8'h20:8'h23]}) return 3;
        if (op inside {[8'h24:8'h27]}) return 6;
        if (op inside {[8'h28:8'h2B]}) return 4;
        if (op inside {[8'h2C:8'h2F]}) return 8;
        if (op inside {[8'h30:8'h33]}) return 5;
        if (op inside {[8'h34:8'h37]}) return 8;
        if (op inside {[8'h38:8'h3B]}) return 7;
        if (op inside {[8'h3C:8'h3F]}) return 11;
        if (op inside {[8'h40:8'h47], [8'h60:8'h63], [8'h74:8'h77], [8'h7C:8'h7F]}) return 2;
        if (op inside {[8'h50:8'h57], [8'h64:8'h67], 8'h80}) return 3;
        if (op inside {[8'h68:8'h6B], [8'h70:8'h73], [8'h78:8'h7B]}) return 1;
        return 0;
    endfunction

    function automatic bit is_term(input logic [31:0] w);
        return (w[31:28] == 4'h5) && (w[15:12] == 4'h5);
    endfunction

    function automatic int exp_len();
        logic [7:0] op = cmd_w[0][31:24];
        if (op inside {[8'h48:8'h4F]}) begin
            for (int v = 3; v < DEPTH; v++) if (is_term(cmd_w[v])) return v + 1;
            return DEPTH;
        end
        if (op inside {[8'h58:8'h5F]}) begin
            for (int v = 4; v < DEPTH; v += 2) if (is_term(cmd_w[v])) return v + 1;
            return DEPTH;
        end
        if (op inside {[8'hA0:8'hDF]}) return 3;
        return 1 + exp_extra(op);
    endfunction

    task automatic send_word(input logic [31:0] w, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    // sends the command held in cmd_w and checks everything it produces
    task automatic run_cmd(input string tag, input int max_gap);
        int n;
        logic [7:0] op;
        logic [12:0] st;
        n  = exp_len();
        op = cmd_w[0][31:24];
        cap_n = 0;
        cap_x = 0;
        for (int i = 0; i < n; i++) send_word(cmd_w[i], (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0);
        wait_idle();
        if (op inside {[8'hA0:8'hDF]}) begin
            check(cap_n == 0 && cap_x == 1, {tag, " R9 xfer only"}, cap_n, 0);
            check(cx_pos == cmd_w[1] && cx_size == cmd_w[2], {tag, " R9 words"}, cx_size, cmd_w[2]);
            check(cx_read == (op >= 8'hC0), {tag, " R9 dir"}, cx_read, (op >= 8'hC0));
        end else begin
            check(cap_n == n && cap_x == 0, {tag, " R2 length"}, cap_n, n);
            if (cap_n == n) begin
                for (int i = 0; i < n; i++) begin
                    logic [15:0] eh;
                    eh = {i == 0, i == n - 1, op, 6'(n)};
                    check(cap_w[i] == cmd_w[i] && cap_h[i] == eh, {tag, " R8 beat"},
                          {cap_w[i][15:0], cap_h[i]}, {cmd_w[i][15:0], eh});
                end
            end
            if (op inside {[8'hE0:8'hE7]}) sh[op[2:0]] = cmd_w[0];
        end
        st = {sh[6][1:0], sh[1][10:0]};
        check(stat_bits == st, {tag, " R11 status"}, stat_bits, st);
        env_sel = 3'($urandom);
        #1;
        check(env_data == sh[env_sel], {tag, " R10 shadow"}, env_data, sh[env_sel]);
    endtask

    function automatic logic [31:0] vert();
        logic [31:0] w = $urandom;
        w[31:28] = 4'h1;
        return w;
    endfunction

    function automatic logic [31:0] term();
        logic [31:0] w = $urandom;
        w[31:28] = 4'h5;
        w[15:12] = 4'h5;
        return w;
    endfunction

    task automatic build_poly(input logic [7:0] op, input int tpos);
        cmd_w[0] = {op, 24'($urandom)};
        for (int i = 1; i < 64; i++) cmd_w[i] = vert();
        if (tpos > 0) cmd_w[tpos] = term();
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) sh[i] = {8'(8'hE0 + i), 24'h0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(in_ready && !pkt_valid && !xfer_valid, "R1 idle outputs", {in_ready, pkt_valid, xfer_valid}, 3'b100);
        check(stat_bits == 13'h0, "R1 status", stat_bits, 0);
        for (int i = 0; i < 8; i++) begin
            env_sel = 3'(i);
            #1;
            check(env_data == sh[i], "R1 shadow reset", env_data, sh[i]);
        end

        // R7 hold incomplete packet over idle gaps
        cmd_w[0] = 32'h2800_1111;
        for (int i = 1; i < 5; i++) cmd_w[i] = $urandom;
        cap_n = 0;
        for (int i = 0; i < 3; i++) send_word(cmd_w[i], 2);
        repeat (10) @(negedge clk);
        check(cap_n == 0 && in_ready, "R7 held incomplete", cap_n, 0);
        for (int i = 3; i < 5; i++) send_word(cmd_w[i], 3);
        wait_idle();
        check(cap_n == 5 && cap_w[4] == cmd_w[4], "R7 release", cap_n, 5);

        // R3 single-word opcodes
        cmd_w[0] = 32'h0012_3456; run_cmd("R3 op00", 0);
        cmd_w[0] = 32'h6C00_0001; run_cmd("R3 op6C", 0);
        cmd_w[0] = 32'hFFAB_CDEF; run_cmd("R3 opFF", 0);
        // R2 longest table entry
        cmd_w[0] = 32'h3F00_0000;
        for (int i = 1; i < 12; i++) cmd_w[i] = $urandom;
        run_cmd("R2 op3F", 1);
        // R4 terminator at earliest position
        build_poly(8'h48, 3); run_cmd("R4 early term", 0);
        // R5 stray terminator at odd index ignored
        build_poly(8'h5A, 6); cmd_w[5] = term(); run_cmd("R5 odd ignored", 0);
        // R6 overflow without terminator
        build_poly(8'h4C, 0); run_cmd("R6 cap", 0);
        build_poly(8'h5F, 0); run_cmd("R6 cap alt", 0);
        // R9 transfers at range edges
        cmd_w[0] = 32'hA000_0000; cmd_w[1] = 32'h0010_0020; cmd_w[2] = 32'h0004_0008; run_cmd("R9 write", 0);
        cmd_w[0] = 32'hDF00_0000; cmd_w[1] = 32'h0001_0002; cmd_w[2] = 32'h0003_0004; run_cmd("R9 read", 2);
        // R10 R11 environment words
        cmd_w[0] = 32'hE100_07FF; run_cmd("R10 env1", 0);
        cmd_w[0] = 32'hE6FF_FFFF; run_cmd("R11 env6", 0);
        cmd_w[0] = 32'hE100_0000; run_cmd("R11 env1 clear", 0);

        // constrained random mix
        for (int it = 0; it < 200; it++) begin
            int cat = $urandom % 6;
            if (cat == 0) begin
                build_poly({5'b01001, 3'($urandom)}, 3 + ($urandom % 20));
            end else if (cat == 1) begin
                build_poly({5'b01011, 3'($urandom)}, 4 + 2 * ($urandom % 10));
            end else if (cat == 2) begin
                cmd_w[0] = {8'(8'hA0 + $urandom % 64), 24'($urandom)};
                cmd_w[1] = $urandom; cmd_w[2] = $urandom;
            end else if (cat == 3) begin
                cmd_w[0] = {5'b11100, 3'($urandom), 24'($urandom)};
            end else begin
                logic [7:0] op;
                do op = 8'($urandom);
                while (op inside {[8'h48:8'h4F], [8'h58:8'h5F], [8'hA0:8'hDF]});
                cmd_w[0] = {op, 24'($urandom)};
                for (int i = 1; i < 12; i++) cmd_w[i] = $urandom;
            end
            run_cmd("rand", 2);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule